// File: doc/BRIEF.md
# PDM Microphone Clock Generator and Dual-Edge Sampler

This block drives the bit clock for up to two pulse-density-modulated microphones and recovers their two one-bit streams from a single shared data wire. The microphones are slaves to the generated clock. One of them drives the wire during the high phase and the other during the low phase. The block captures the wire just before each clock edge and routes the bit to the left or right channel. Each channel has its own bit output and a one-cycle valid strobe, both synchronous to the fast system clock.

The output clock comes from an integer half-period counter that runs on the system clock. Both the high and the low phase of the output clock last an exact whole number of system cycles, so the output adds no jitter beyond that of the source. A new half-period value is taken only at the falling edge that closes a full period, or when the clock starts.

An enable input starts the clock and stops it. On a stop, the period in progress runs to completion and the clock then parks low. A swap input reverses which edge feeds which channel. Decimation, PCM conversion and memory transfer belong to later stages.

Top module: `pdm_mic_clk_sampler`

## Requirements
- R1: While rst_ni is low, pdm_clk_o, left_vld_o and right_vld_o are all 0.
- R2: While disabled and parked, pdm_clk_o shows no edges and neither valid strobe is asserted.
- R3: With a half-period value N (N ≥ 1), every high phase and every low phase of pdm_clk_o lasts exactly N system cycles. The first low phase counts from the cycle in which en_i is first seen high.
- R4: A half-period value of 0 behaves exactly as a value of 1.
- R5: half_div_i is taken when the clock starts, and again only at each falling edge of pdm_clk_o. That falling edge uses the value present in the system cycle before it, and the value then holds for the full period that follows.
- R6: With swap_i = 0, a rising edge of pdm_clk_o produces a right-channel sample and a falling edge produces a left-channel sample. The sample bit equals pdm_din_i in the system cycle before the edge is driven.
- R7: With swap_i = 1 in the cycle before an edge, the mapping is reversed: a rising edge produces a left sample and a falling edge produces a right sample.
- R8: Every edge of pdm_clk_o comes with exactly one valid pulse, lasting one cycle, in the same cycle that the new clock level appears. No valid pulse occurs without an edge, and the two strobes are never asserted together.
- R9: When en_i is low at a falling edge, that edge and its left/right sample still occur. pdm_clk_o then stays low and no further strobes are issued until en_i is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request for the microphone clock |
| swap_i | input | 1 | 0: right on rising and left on falling; 1: reversed |
| half_div_i | input | DIV_W | Half-period in system cycles (0 treated as 1) |
| pdm_din_i | input | 1 | Shared microphone data wire |
| pdm_clk_o | output | 1 | Generated microphone clock |
| left_bit_o | output | 1 | Latest left-channel bit |
| left_vld_o | output | 1 | One-cycle strobe for a new left bit |
| right_bit_o | output | 1 | Latest right-channel bit |
| right_vld_o | output | 1 | One-cycle strobe for a new right bit |

## Verification
Several events can land on the same falling edge: the half-period reload, the stop decision, and the left/right sample with its strobe. The bench changes half_div_i while the clock is high and while it is low, and lowers en_i during a high phase. The scoreboard then checks that the closing falling edge still delivers its strobe, that the measured phase lengths switch exactly at that edge, and that the clock afterwards stays parked. A swap change made in the cycle just before an edge is judged against the value the bench recorded at that same system edge.

// File: rtl/pdm_sampler_pkg.sv
package pdm_sampler_pkg;
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
  localparam int unsigned NUM_CH = 2;

  // channel takes the rising edge: right by default, left when swapped
  function automatic logic takes_rise(chan_e ch, logic swap);
    return (ch == CH_RIGHT) ^ swap;
  endfunction
endpackage

// File: rtl/pdm_half_div.sv
module pdm_half_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             pclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic             run_q, clk_q;
  logic [DIV_W-1:0] cnt_q, half_q, half_eff;
  logic             tick;

  assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
  assign tick     = run_q && (cnt_q == '0);
  assign rise_o   = tick && !clk_q;
  assign fall_o   = tick && clk_q;
  assign pclk_o   = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      clk_q  <= 1'b0;
      cnt_q  <= '0;
      half_q <= DIV_W'(1);
    end else if (!run_q) begin
      if (en_i) begin
        run_q  <= 1'b1;
        half_q <= half_eff;
        cnt_q  <= half_eff - DIV_W'(1);
      end
    end else if (tick) begin
      clk_q <= ~clk_q;
      if (clk_q) begin
        // falling edge closes a period: reload divider, honour stop
        if (!en_i) run_q <= 1'b0;
        half_q <= half_eff;
        cnt_q  <= half_eff - DIV_W'(1);
      end else begin
        cnt_q <= half_q - DIV_W'(1);
      end
    end else begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end
endmodule

// File: rtl/pdm_chan_capture.sv
module pdm_chan_capture
  import pdm_sampler_pkg::*;
#(
  parameter chan_e CH = CH_LEFT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic fall_i,
  input  logic swap_i,
  input  logic din_i,
  output logic bit_o,
  output logic vld_o
);
  logic take;

  assign take = takes_rise(CH, swap_i) ? rise_i : fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= take;
      if (take) bit_o <= din_i;
    end
  end
endmodule

// File: rtl/pdm_mic_clk_sampler.sv
module pdm_mic_clk_sampler
  import pdm_sampler_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             swap_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             pdm_din_i,
  output logic             pdm_clk_o,
  output logic             left_bit_o,
  output logic             left_vld_o,
  output logic             right_bit_o,
  output logic             right_vld_o
);
  logic              rise_w, fall_w;
  logic [NUM_CH-1:0] bit_w, vld_w;

  pdm_half_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .half_i (half_div_i),
    .pclk_o (pdm_clk_o),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pdm_chan_capture #(.CH(chan_e'(c))) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rise_i (rise_w),
      .fall_i (fall_w),
      .swap_i (swap_i),
      .din_i  (pdm_din_i),
      .bit_o  (bit_w[c]),
      .vld_o  (vld_w[c])
    );
  end

  assign left_bit_o  = bit_w[int'(CH_LEFT)];
  assign left_vld_o  = vld_w[int'(CH_LEFT)];
  assign right_bit_o = bit_w[int'(CH_RIGHT)];
  assign right_vld_o = vld_w[int'(CH_RIGHT)];
endmodule

// File: rtl/pdm_sampler_chk.sv
module pdm_sampler_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic swap_i,
  input logic pdm_din_i,
  input logic pdm_clk_o,
  input logic left_bit_o,
  input logic left_vld_o,
  input logic right_bit_o,
  input logic right_vld_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!pdm_clk_o && !left_vld_o && !right_vld_o);
    end
  end

  // R8
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(left_vld_o && right_vld_o));

  // R8
  strobe_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    (left_vld_o || right_vld_o) |-> (pdm_clk_o != $past(pdm_clk_o)));

  // R6
  right_edge_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    right_vld_o |-> (pdm_clk_o == !$past(swap_i)));

  // R7
  left_edge_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    left_vld_o |-> (pdm_clk_o == $past(swap_i)));

  // R6
  left_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    left_vld_o |-> (left_bit_o == $past(pdm_din_i)));

  // R6
  right_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    right_vld_o |-> (right_bit_o == $past(pdm_din_i)));

  // R9
  park_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    ($fell(pdm_clk_o) && !$past(en_i)) |=> !pdm_clk_o);
endmodule

bind pdm_mic_clk_sampler pdm_sampler_chk u_chk (.*);

// File: tb/pdm_mic_clk_sampler_test.sv
module pdm_mic_clk_sampler_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, swap = 1'b0, din = 1'b0;
  logic [DIV_W-1:0] half = DIV_W'(3);
  logic pclk, lbit, lvld, rbit, rvld;

  int checks = 0, errors = 0;
  int edge_cnt = 0;
  string len_tag = "R3";

  always #(CLK_PERIOD/2) clk = ~clk;

  pdm_mic_clk_sampler #(.DIV_W(DIV_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .swap_i(swap), .half_div_i(half),
    .pdm_din_i(din), .pdm_clk_o(pclk), .left_bit_o(lbit), .left_vld_o(lvld),
    .right_bit_o(rbit), .right_vld_o(rvld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(input logic [DIV_W-1:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  // inputs as seen at each rising system edge
  logic din_s = 1'b0, swap_s = 1'b0, en_s = 1'b0;
  logic [DIV_W-1:0] div_s = '0;
  always @(posedge clk) begin
    din_s  <= din;
    swap_s <= swap;
    en_s   <= en;
    div_s  <= half;
  end

  always @(negedge clk) din <= 1'($urandom);

  // scoreboard: {channel(1=right), bit}
  logic [1:0] exp_q[$];
  logic pclk_last = 1'b0;
  bit   run_m = 0;
  int   half_m = 1, len = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pclk != pclk_last) begin
        edge_cnt++;
        check(run_m, "R2 edge while parked", 1, 0);
        check(len + 1 == half_m, len_tag, len + 1, half_m);
        len = 0;
        exp_q.push_back({pclk ^ swap_s, din_s});
        if (!pclk) begin
          half_m = eff(div_s);
          if (!en_s) run_m = 0;
        end
      end else if (run_m) begin
        len++;
      end else if (en_s) begin
        run_m = 1;
        half_m = eff(div_s);
        len = 0;
      end
      pclk_last = pclk;

      if (lvld && rvld) check(0, "R8 both strobes", 2, 1);
      if (lvld || rvld) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 strobe without edge", 1, 0);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          check(rvld == e[1], swap_s ? "R7 channel" : "R6 channel", int'(rvld), int'(e[1]));
          check((rvld ? rbit : lbit) == e[0], swap_s ? "R7 bit" : "R6 bit",
                int'(rvld ? rbit : lbit), int'(e[0]));
        end
      end
      if (exp_q.size() != 0) begin
        check(0, "R8 missing strobe", 0, 1);
        exp_q.delete();
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_level(input logic lvl);
    while (pclk !== lvl) @(negedge clk);
  endtask

  initial begin
    int e0;
    cyc(3);
    check(pclk == 0, "R1 clk", int'(pclk), 0);
    check(!lvld && !rvld, "R1 strobes", int'({lvld, rvld}), 0);
    rst_n = 1'b1;
    cyc(2);
    check(pclk == 0, "R1 clk after reset", int'(pclk), 0);

    cyc(20);
    check(edge_cnt == 0, "R2 idle edges", edge_cnt, 0);

    len_tag = "R3";
    en = 1'b1;
    cyc(60);
    check(edge_cnt >= 15, "R3 edges produced", edge_cnt, 15);

    len_tag = "R5";
    wait_level(1'b1);
    half = DIV_W'(5);
    cyc(60);
    wait_level(1'b0);
    half = DIV_W'(2);
    cyc(40);

    len_tag = "R3";
    swap = 1'b1;
    e0 = edge_cnt;
    cyc(40);
    check(edge_cnt - e0 >= 15, "R7 edges under swap", edge_cnt - e0, 15);
    wait_level(1'b1);
    cyc(1);
    swap = 1'b0;
    cyc(30);

    len_tag = "R4";
    half = '0;
    cyc(4);
    e0 = edge_cnt;
    cyc(30);
    check(edge_cnt - e0 >= 28, "R4 zero acts as one", edge_cnt - e0, 28);
    half = DIV_W'(1);
    cyc(20);

    len_tag = "R3";
    half = DIV_W'(4);
    cyc(30);
    wait_level(1'b1);
    en = 1'b0;
    cyc(10);
    e0 = edge_cnt;
    cyc(30);
    check(edge_cnt == e0, "R9 no edges after stop", edge_cnt - e0, 0);
    check(pclk == 0, "R9 parked low", int'(pclk), 0);

    en = 1'b1;
    half = DIV_W'(2);
    cyc(20);
    check(edge_cnt - e0 >= 6, "R9 restart", edge_cnt - e0, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule